// File: doc/BRIEF.md
# Serial EEPROM Target Controller

This block answers as a two-wire (I2C) target in front of a 256-byte register file that behaves like a serial EEPROM. It watches the sampled clock and data lines and detects start and stop conditions. It shifts in the device byte and checks it against a fixed type code and three strap pins. It drives the data line only through an open-drain pull-down enable.

A word-address counter keeps its value from one transaction to the next. Reads advance the counter across the whole array and wrap from 0xFF to 0x00. Writes wrap within the current 8-byte page. The counter therefore supports byte write, page write, current-address read, random read (a dummy write that only loads the counter, then a repeated start) and sequential read.

A write transaction that stores at least one data byte and then ends with a stop starts a busy period of `BUSY_CYCLES` clocks. During that period the target refuses its device address, so a master can poll until the write has finished.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) a device byte whose bits [7:4] are 4'b1010 and bits [3:1] equal `strap_i`; any other device byte gets no acknowledge and the transaction is ignored until the next start.
- R2: After a write transaction that stored data ends with a stop, the device address is not acknowledged for `BUSY_CYCLES` clocks; afterwards it is acknowledged again.
- R3: In a write transaction (device byte bit 0 = 0), the first byte after the device byte loads the word address and each following byte is stored at the counter; a later read of that address returns it.
- R4: During writes the counter advances within its 8-byte page: from offset 7 it returns to offset 0 of the same page, and the upper five address bits are unchanged.
- R5: A read transaction (device byte bit 0 = 1) with no preceding address returns the byte at the counter, which holds the last accessed address plus one and keeps it between transactions.
- R6: A write transaction carrying only a word address, ended by a stop, changes the counter but not the array and starts no busy period.
- R7: During a read, each byte acknowledged by the master is followed by the next byte; the counter wraps from 0xFF to 0x00.
- R8: When the master does not acknowledge a read byte, the target releases SDA (`sda_oe` = 0) and stays idle until the next start.
- R9: A start or stop received before a byte is complete aborts the operation; the partial byte is not stored and no busy period begins.
- R10: After reset, `sda_oe` is 0, the counter is 0 and every array byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| strap_i | input | 3 | Device address select bits |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
A wrong word-address counter shows up at the next read. A current-address read, or the second byte of a sequential read, returns a byte from the wrong location, and a page write spills into the neighbouring page. This becomes visible within one read transaction after the faulty step. A busy timer that is stuck, or that ends too early, changes the acknowledge on the very first poll after a stop. A partial byte that the abort path should have discarded is detected when that address is read back. The bench checks every returned byte against a model memory that it updates from the requirements.

// File: rtl/eeprom_tgt_pkg.sv
// Shared types for the serial EEPROM target.
package eeprom_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_monitor.sv
// Registers the sampled bus lines once and derives clock edges and
// start/stop conditions from the current and previous register values.
// Assumes scl_i/sda_i are already synchronous to clk.
module i2c_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_s
);
    logic scl_s, scl_p, sda_p;

    // Two-stage history of both lines; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_s <= 1'b1;
            scl_p <= 1'b1;
            sda_s <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= scl_i;
            scl_p <= scl_s;
            sda_s <= sda_i;
            sda_p <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_evt = scl_s & scl_p & sda_p & ~sda_s;
        stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/eeprom_array.sv
// Byte register file standing in for the nonvolatile array.
// One synchronous write port, one combinational read port; cleared on reset.
module eeprom_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, else single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/eeprom_busy_timer.sv
// Counts down the internal write cycle. A start pulse loads CYCLES;
// busy_o is high while the count is non-zero.
module eeprom_busy_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise drain to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_i) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    p_busy_drains_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/eeprom_tgt_fsm.sv
// Protocol engine: receives device, address and data bytes, returns read
// bytes, owns the word-address counter and the SDA pull-down enable.
// Assumes SCL low phases last at least a few clocks so the SDA update
// that follows a falling edge settles before SCL rises again.
module eeprom_tgt_fsm
    import eeprom_tgt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        rdata_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              busy_start,
    output logic              sda_oe
);
    localparam int HI_W = ADDR_W - PAGE_W;

    tgt_state_e        state;
    rx_kind_e          kind;
    logic [2:0]        bitcnt;
    logic              got8;
    logic [7:0]        shreg;
    logic [7:0]        txbyte;
    logic              ack_to_tx;
    logic              mack_q;
    logic              wr_dirty;
    logic [ADDR_W-1:0] addr_ctr;

    logic              quiet;
    logic              byte_eval;
    logic              dev_ok;
    logic              tx_load;
    logic [ADDR_W-1:0] page_next;

    // Event qualification and next-address arithmetic.
    always_comb begin
        quiet     = !start_evt && !stop_evt;
        byte_eval = (state == ST_RX) && got8 && scl_fall && quiet;
        dev_ok    = (shreg[7:1] == {DEV_TYPE, strap_i}) && !busy_i;
        tx_load   = quiet && scl_fall &&
                    (((state == ST_ACK) && ack_to_tx) || ((state == ST_MACK) && mack_q));
        page_next = {addr_ctr[ADDR_W-1:PAGE_W], addr_ctr[PAGE_W-1:0] + 1'b1};
        mem_we    = byte_eval && (kind == K_WDATA);
        busy_start = stop_evt && wr_dirty;
    end

    assign mem_addr  = addr_ctr;
    assign mem_wdata = shreg;

    // Tracks whether the current write transaction stored any data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_dirty <= 1'b0;
        else if (start_evt || stop_evt) wr_dirty <= 1'b0;
        else if (mem_we) wr_dirty <= 1'b1;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= K_DEV;
            bitcnt    <= '0;
            got8      <= 1'b0;
            shreg     <= '0;
            txbyte    <= '0;
            ack_to_tx <= 1'b0;
            mack_q    <= 1'b0;
            addr_ctr  <= '0;
            sda_oe    <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
            got8   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            got8   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            if (tx_load) begin
                txbyte   <= rdata_i;
                sda_oe   <= ~rdata_i[7];
                addr_ctr <= addr_ctr + 1'b1;
                bitcnt   <= '0;
                state    <= ST_TX;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && !got8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (byte_eval) begin
                            got8   <= 1'b0;
                            bitcnt <= '0;
                            case (kind)
                                K_DEV: begin
                                    if (dev_ok) begin
                                        state     <= ST_ACK;
                                        sda_oe    <= 1'b1;
                                        ack_to_tx <= shreg[0];
                                        kind      <= K_WADDR;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                K_WADDR: begin
                                    addr_ctr  <= shreg[ADDR_W-1:0];
                                    state     <= ST_ACK;
                                    sda_oe    <= 1'b1;
                                    ack_to_tx <= 1'b0;
                                    kind      <= K_WDATA;
                                end
                                default: begin
                                    addr_ctr  <= page_next;
                                    state     <= ST_ACK;
                                    sda_oe    <= 1'b1;
                                    ack_to_tx <= 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            got8   <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                state  <= ST_MACK;
                                sda_oe <= 1'b0;
                            end else begin
                                txbyte <= {txbyte[6:0], 1'b0};
                                sda_oe <= ~txbyte[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    p_busy_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_eval && kind == K_DEV && busy_i) |=> (state == ST_IDLE && !sda_oe));
    p_foreign_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_eval && kind == K_DEV && shreg[7:4] != DEV_TYPE) |=> (state == ST_IDLE));
    p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr_ctr[ADDR_W-1:PAGE_W] == $past(addr_ctr[ADDR_W-1:PAGE_W]) &&
                    addr_ctr[PAGE_W-1:0] == $past(addr_ctr[PAGE_W-1:0]) + 1'b1));
    p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (addr_ctr == $past(addr_ctr) + 1'b1));
    p_abort_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |-> !mem_we);
endmodule

// File: rtl/i2c_eeprom_target.sv
// Top level: two-wire target in front of a byte array, with page-wrapping
// writes, array-wrapping reads and a busy period after each stored write.
module i2c_eeprom_target #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe
);
    logic              scl_rise, scl_fall, start_evt, stop_evt, sda_s;
    logic              busy, busy_start, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    i2c_line_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s)
    );

    eeprom_tgt_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .sda_s      (sda_s),
        .strap_i    (strap_i),
        .busy_i     (busy),
        .rdata_i    (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .busy_start (busy_start),
        .sda_oe     (sda_oe)
    );

    eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    eeprom_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_start),
        .busy_o  (busy)
    );
endmodule

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
    localparam int Q = 4;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int n_tests = 0;
    int n_fail = 0;

    logic [7:0] model [256];
    logic [7:0] ctr_m;
    logic [7:0] wbuf [16];

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_eeprom_target u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .strap_i (STRAP),
        .sda_oe  (sda_oe)
    );

    function automatic logic [7:0] pg_next(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
        ack = (sda_bus == 1'b0);
        qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
            b[i] = sda_bus;
            qw(); scl_m = 1'b0; qw();
        end
        sda_m = ~mack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    // Poll with write-addressed headers until acknowledged.
    task automatic wait_ready(output int polls, output bit first_ack);
        bit ack;
        polls = 0;
        first_ack = 1'b0;
        for (int k = 0; k < 60; k++) begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            polls++;
            if (k == 0) first_ack = ack;
            if (ack) break;
        end
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R1", ack, 1);
        send_byte(a, ack);
        chk(ack, "R3", ack, 1);
        ctr_m = a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, req, ack, 1);
            model[ctr_m] = wbuf[k];
            ctr_m = pg_next(ctr_m);
        end
        bus_stop();
    endtask

    task automatic read_tail(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(b == model[ctr_m], req, b, model[ctr_m]);
            ctr_m = ctr_m + 8'd1;
        end
        chk(sda_oe == 1'b0, "R8", sda_oe, 0);
        bus_stop();
    endtask

    task automatic do_read_at(input logic [7:0] a, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(a, ack);
        ctr_m = a;
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R1", ack, 1);
        read_tail(n, req);
    endtask

    task automatic do_cur_read(input int n, input string req);
        bit ack;
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R5", ack, 1);
        read_tail(n, req);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int polls;
        bit fa, ack;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        ctr_m = 8'h00;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10 / R5: counter starts at 0, array cleared
        do_cur_read(2, "R10");

        // R1: wrong strap and wrong type code are not acknowledged
        bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, ack); bus_stop();
        chk(!ack, "R1", ack, 0);
        bus_start(); send_byte({4'b0101, STRAP, 1'b1}, ack); bus_stop();
        chk(!ack, "R1", ack, 0);

        // R3 byte write + R2 busy polling
        wbuf[0] = 8'hA5;
        do_write(8'h20, 1, "R3");
        wait_ready(polls, fa);
        chk(!fa, "R2", fa, 0);
        chk(polls > 1 && polls < 60, "R2", polls, 5);
        do_read_at(8'h20, 1, "R3");

        // R4 page write wrapping inside page 0x38..0x3F
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h10 + 8'(k);
        do_write(8'h3E, 4, "R4");
        wait_ready(polls, fa);
        do_read_at(8'h38, 8, "R4");
        chk(model[8'h40] == 8'h00, "R4", model[8'h40], 0);

        // R5 current-address reads persist across transactions
        do_cur_read(1, "R5");
        do_cur_read(1, "R5");

        // R7 sequential read across 0xFF -> 0x00
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        do_write(8'hFE, 2, "R7");
        wait_ready(polls, fa);
        do_read_at(8'hFE, 4, "R7");

        // R6 address-only write: counter loads, no busy, array unchanged
        bus_start(); send_byte(DEV_W, ack); send_byte(8'h21, ack); bus_stop();
        ctr_m = 8'h21;
        wait_ready(polls, fa);
        chk(fa, "R6", fa, 1);
        do_cur_read(1, "R6");

        // R9 stop in mid byte: nothing stored, no busy
        bus_start(); send_byte(DEV_W, ack); send_byte(8'h20, ack);
        send_bits(8'h3C, 4);
        bus_stop();
        wait_ready(polls, fa);
        chk(fa, "R9", fa, 1);
        do_read_at(8'h20, 1, "R9");
        // R9 start in mid byte
        bus_start(); send_byte(DEV_W, ack); send_byte(8'h38, ack);
        send_bits(8'hFF, 3);
        bus_start(); bus_stop();
        wait_ready(polls, fa);
        chk(fa, "R9", fa, 1);
        do_read_at(8'h38, 2, "R9");

        // Random page writes and reads checked against the model
        for (int it = 0; it < 10; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 10);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(a, n, "R4");
            wait_ready(polls, fa);
            chk(!fa, "R2", fa, 0);
            do_read_at(8'($urandom), 1 + int'($urandom % 12), "R7");
            do_cur_read(1 + int'($urandom % 3), "R5");
        end

        finish_run();
    end
endmodule